// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block buffers 36-bit words from a write port to a read port. Each port runs on its own free-running clock. The two clocks may be unrelated, or they may share the same edges. A word moves on the rising edge of its port's clock, and only while that port's enable is high.

The write side has two flags, input-ready and almost-full. The read side has two flags, output-ready and almost-empty. Each flag is computed in its own clock domain from the other side's pointer. That pointer crosses as Gray code through a two-stage synchronizer.

The almost thresholds are programmable. They can be loaded in one cycle from the write data bus, or shifted in one bit at a time on a serial input. Retransmit control lets a reader mark a position in the stream and rewind to it later. While a mark is held, the marked words stay protected from being overwritten.

Top module: `retx_fifo`

## Requirements
- R1: Words come out on `rdData` in the order they were accepted. A word is accepted on a `wrClk` edge where `wrEn` and `inReady` are both high and `cfgLoad` is low. `rdData` changes on the `rdClk` edge that accepts a read, which is an edge where `rdEn` and `outReady` are both high.
- R2: `inReady` is low while DEPTH words are held. A write attempted while `inReady` is low stores nothing and moves no pointer.
- R3: `outReady` is low while the FIFO is empty. A read attempted while `outReady` is low returns nothing and moves no pointer.
- R4: Once the pointers have settled, `almostFull` is high exactly when the stored count is at least DEPTH minus the almost-full offset.
- R5: Once the pointers have settled, `almostEmpty` is high exactly when the stored count is at most the almost-empty offset.
- R6: Reset is synchronous and clears both pointers. It sets both offsets to 8. During reset, `inReady` and `outReady` are low and `almostEmpty` is high. After reset, `inReady` rises.
- R7: A `wrClk` edge with `cfgLoad` high does three things: it loads the almost-full offset from `wrData` bits [OFF_W-1:0], it loads the almost-empty offset from `wrData` bits [18+OFF_W-1:18], and it stores no word.
- R8: On each `wrClk` edge with `serEn` high, the chain {almost-empty offset, almost-full offset} shifts left by one and takes `serIn` as its new least significant bit. Sending the almost-empty value most significant bit first, followed by the almost-full value most significant bit first, loads both offsets.
- R9: A pulse on `rtMark` saves the read position. A later pulse on `rtGo` rewinds to it, and the words from the mark onward are then read again in their original order.
- R10: While a mark is held, the write side counts the marked position as the oldest stored word, so marked data is never overwritten. A pulse on `rtDrop` releases the mark.
- R11: A pulse on `rtGo` when no mark is held is ignored.
- R12: Data order and flag behaviour hold when `wrClk` and `rdClk` are asynchronous to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-port clock |
| wrRst | input | 1 | Synchronous reset, write domain |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write data; also carries the offsets during a parallel load |
| cfgLoad | input | 1 | Load both offsets from `wrData` |
| serEn | input | 1 | Shift enable for the serial offset chain |
| serIn | input | 1 | Serial offset bit |
| inReady | output | 1 | High when there is room to write |
| almostFull | output | 1 | Programmable almost-full flag |
| rdClk | input | 1 | Read-port clock |
| rdRst | input | 1 | Synchronous reset, read domain |
| rdEn | input | 1 | Read enable |
| rtMark | input | 1 | Save the read position and start holding it |
| rtGo | input | 1 | Rewind to the saved position |
| rtDrop | input | 1 | Release the saved position |
| rdData | output | DATA_W | Registered read data |
| outReady | output | 1 | High when a word is available to read |
| almostEmpty | output | 1 | Programmable almost-empty flag |

## Verification
The bench fills the FIFO to exactly DEPTH and then pushes past it. A design with an off-by-one full compare would overwrite the oldest word, and the full-depth read-back would show it. It also reads an empty FIFO and then checks that the next word written comes out unchanged, which catches a pointer that slips on an ignored read.

Retransmit is tested three ways. A mark followed by a rewind must replay the marked words in order. A held mark must keep `inReady` low after reads until the mark is dropped. A design that tracked the live read pointer instead of the mark would reopen space early. A rewind with no mark held must leave the stream untouched.

Both offset paths are driven with values far from the defaults, so a swapped field or a reversed shift order moves a flag at the wrong count. The read clock is then made asynchronous, so any multi-bit jump in a crossing pointer would show up as corrupted data or flags.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;

  // Offset value loaded into both thresholds by reset
  localparam int DEF_OFF = 8;

  // Per-cycle strobes from control to the storage array
  typedef struct packed {
    logic wrStb;   // write-domain store strobe
    logic rdStb;   // read-domain fetch strobe
  } fifoStbT;

endpackage

// File: rtl/retx_fifo_sync.sv
module retx_fifo_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/retx_fifo_mem.sv
module retx_fifo_mem
  import retx_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  fifoStbT           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [DATA_W-1:0] store [ENTRIES];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (stb.rdStb) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OFF_W  = 9
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  input  logic              cfgLoad,
  input  logic [OFF_W-1:0]  cfgAf,
  input  logic [OFF_W-1:0]  cfgAe,
  input  logic              serEn,
  input  logic              serIn,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  input  logic              rtMark,
  input  logic              rtGo,
  input  logic              rtDrop,
  output fifoStbT           stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              inReady,
  output logic              almostFull,
  output logic              outReady,
  output logic              almostEmpty
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0]    wrBin, wrGray, wrBinNext, wrGrayNext;
  logic [PW-1:0]    tailGray, tailGraySync, tailBinSync, wrLevel;
  logic [OFF_W-1:0] afOff, aeOff;
  logic             wrAcc, fullNext, afNext;

  retx_fifo_sync #(.W(PW)) u_tailSync (
    .clk(wrClk), .rst(wrRst), .d(tailGray), .q(tailGraySync)
  );

  always_comb begin
    wrAcc       = wrEn && inReady && !cfgLoad;
    wrBinNext   = wrBin + PW'(wrAcc);
    wrGrayNext  = toGray(wrBinNext);
    tailBinSync = toBin(tailGraySync);
    wrLevel     = wrBinNext - tailBinSync;
    fullNext    = wrGrayNext == {~tailGraySync[PW-1:PW-2], tailGraySync[PW-3:0]};
    afNext      = wrLevel >= (DEPTH_P - PW'(afOff));
  end

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrBin      <= '0;
      wrGray     <= '0;
      inReady    <= 1'b0;
      almostFull <= 1'b0;
      afOff      <= OFF_W'(DEF_OFF);
      aeOff      <= OFF_W'(DEF_OFF);
    end else begin
      wrBin      <= wrBinNext;
      wrGray     <= wrGrayNext;
      inReady    <= !fullNext;
      almostFull <= afNext;
      if (cfgLoad) begin
        afOff <= cfgAf;
        aeOff <= cfgAe;
      end else if (serEn) begin
        {aeOff, afOff} <= {aeOff[OFF_W-2:0], afOff, serIn};
      end
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdBinNext, markBin, tailBin, tailBinNext, tailLimit;
  logic [PW-1:0] wrGraySync, wrBinSync, rdLevel;
  logic          retain, goOk, rdAcc, emptyNext, aeNext;

  retx_fifo_sync #(.W(PW)) u_wrSync (
    .clk(rdClk), .rst(rdRst), .d(wrGray), .q(wrGraySync)
  );

  always_comb begin
    goOk        = rtGo && retain;
    rdAcc       = rdEn && outReady && !goOk;
    rdBinNext   = goOk ? markBin : rdBin + PW'(rdAcc);
    // the tail walks one step per cycle so its Gray code never jumps
    tailLimit   = retain ? markBin : rdBin;
    tailBinNext = tailBin + PW'(tailBin != tailLimit);
    wrBinSync   = toBin(wrGraySync);
    emptyNext   = toGray(rdBinNext) == wrGraySync;
    rdLevel     = wrBinSync - rdBinNext;
    aeNext      = rdLevel <= PW'(aeOff);
  end

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdBin       <= '0;
      markBin     <= '0;
      tailBin     <= '0;
      tailGray    <= '0;
      retain      <= 1'b0;
      outReady    <= 1'b0;
      almostEmpty <= 1'b1;
    end else begin
      rdBin       <= rdBinNext;
      tailBin     <= tailBinNext;
      tailGray    <= toGray(tailBinNext);
      outReady    <= !emptyNext;
      almostEmpty <= aeNext;
      if (rtMark) begin
        markBin <= rdBin;
        retain  <= 1'b1;
      end else if (rtDrop) begin
        retain  <= 1'b0;
      end
    end
  end

  assign stb.wrStb = wrAcc;
  assign stb.rdStb = rdAcc;
  assign wrAddr    = wrBin[ADDR_W-1:0];
  assign rdAddr    = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgLoad,
  input  logic              serEn,
  input  logic              serIn,
  output logic              inReady,
  output logic              almostFull,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  input  logic              rtMark,
  input  logic              rtGo,
  input  logic              rtDrop,
  output logic [DATA_W-1:0] rdData,
  output logic              outReady,
  output logic              almostEmpty
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OFF_W  = ADDR_W;
  localparam int AE_LSB = DATA_W / 2;

  fifoStbT           stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  retx_fifo_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .cfgLoad(cfgLoad),
    .cfgAf(wrData[OFF_W-1:0]), .cfgAe(wrData[AE_LSB +: OFF_W]),
    .serEn(serEn), .serIn(serIn),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn),
    .rtMark(rtMark), .rtGo(rtGo), .rtDrop(rtDrop),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inReady(inReady), .almostFull(almostFull),
    .outReady(outReady), .almostEmpty(almostEmpty)
  );

  retx_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wrClk(wrClk), .rdClk(rdClk), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk #(
  parameter int ADDR_W = 9
) (
  input logic              wrClk,
  input logic              wrRst,
  input logic              wrEn,
  input logic              inReady,
  input logic              almostFull,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              rdClk,
  input logic              rdRst,
  input logic              rdEn,
  input logic              rtGo,
  input logic              outReady,
  input logic              almostEmpty,
  input logic [ADDR_W-1:0] rdAddr
);
  // R2
  wr_hold_full_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    (!inReady && wrEn) |=> $stable(wrAddr));

  // R3
  rd_hold_empty_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    (!outReady && rdEn && !rtGo) |=> $stable(rdAddr));

  // R4
  full_sets_af_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    (!inReady && !$past(wrRst)) |-> almostFull);

  // R5
  ae_low_ready_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    !almostEmpty |-> outReady);

  // R1
  wr_single_step_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    1'b1 |=> (wrAddr == $past(wrAddr) || wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));
endmodule

bind retx_fifo retx_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/retx_fifo_bench.sv
`timescale 1ns/1ps
module retx_fifo_bench;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 512;
  localparam int OFF_W  = 9;
  localparam int AE_LSB = 18;

  typedef struct packed {
    int   nW;
    int   nR;
    logic ir;
    logic af;
    logic orr;
    logic ae;
  } stepT;

  // cumulative counts: 4, 9, 8, 504, 512, 512 (writes refused), 0, 0 (reads refused), 0
  localparam stepT STEPS [9] = '{
    '{4,   0,   1'b1, 1'b0, 1'b1, 1'b1},
    '{5,   0,   1'b1, 1'b0, 1'b1, 1'b0},
    '{0,   1,   1'b1, 1'b0, 1'b1, 1'b1},
    '{496, 0,   1'b1, 1'b1, 1'b1, 1'b0},
    '{8,   0,   1'b0, 1'b1, 1'b1, 1'b0},
    '{3,   0,   1'b0, 1'b1, 1'b1, 1'b0},
    '{0,   512, 1'b1, 1'b0, 1'b0, 1'b1},
    '{0,   2,   1'b1, 1'b0, 1'b0, 1'b1},
    '{1,   1,   1'b1, 1'b0, 1'b0, 1'b1}
  };

  logic wrClk = 0, rdClk = 0;
  logic wrRst = 1, rdRst = 1;
  logic wrEn = 0, cfgLoad = 0, serEn = 0, serIn = 0;
  logic rdEn = 0, rtMark = 0, rtGo = 0, rtDrop = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic inReady, almostFull, outReady, almostEmpty;

  realtime wrHalf = 2.0, rdHalf = 2.0;
  int tests = 0, fails = 0;
  int wrSeq = 0, rdSeq = 0, markSeq = 0;

  always #(wrHalf) wrClk = ~wrClk;
  always #(rdHalf) rdClk = ~rdClk;

  retx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_retx_fifo (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .wrData(wrData),
    .cfgLoad(cfgLoad), .serEn(serEn), .serIn(serIn),
    .inReady(inReady), .almostFull(almostFull),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn),
    .rtMark(rtMark), .rtGo(rtGo), .rtDrop(rtDrop),
    .rdData(rdData), .outReady(outReady), .almostEmpty(almostEmpty)
  );

  function automatic logic [DATA_W-1:0] word(input int i);
    return {4'h5, 32'(i)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkFlags(input string ctx, input logic ir, input logic af,
                          input logic orr, input logic ae);
    chk({"R2 inReady ", ctx}, 64'(inReady), 64'(ir));
    chk({"R4 almostFull ", ctx}, 64'(almostFull), 64'(af));
    chk({"R3 outReady ", ctx}, 64'(outReady), 64'(orr));
    chk({"R5 almostEmpty ", ctx}, 64'(almostEmpty), 64'(ae));
  endtask

  task automatic settle();
    repeat (24) @(negedge wrClk);
    repeat (24) @(negedge rdClk);
  endtask

  task automatic writeN(input int n);
    for (int i = 0; i < n; i++) begin
      logic acc;
      @(negedge wrClk);
      acc    = inReady;
      wrEn   = 1'b1;
      wrData = acc ? word(wrSeq) : {4'hB, 32'hBAD0_0000 | 32'(i)};
      @(negedge wrClk);
      wrEn = 1'b0;
      if (acc) wrSeq++;
    end
  endtask

  task automatic readN(input int nAcc, input int maxTry, input string tag);
    int got = 0;
    for (int t = 0; t < maxTry && got < nAcc; t++) begin
      logic acc;
      @(negedge rdClk);
      acc  = outReady;
      rdEn = 1'b1;
      @(negedge rdClk);
      rdEn = 1'b0;
      if (acc) begin
        chk(tag, 64'(rdData), 64'(word(rdSeq)));
        rdSeq++;
        got++;
      end
    end
  endtask

  task automatic pulseRd(input int which);
    @(negedge rdClk);
    case (which)
      0: rtMark = 1'b1;
      1: rtGo   = 1'b1;
      default: rtDrop = 1'b1;
    endcase
    @(negedge rdClk);
    rtMark = 1'b0; rtGo = 1'b0; rtDrop = 1'b0;
  endtask

  task automatic doReset();
    wrRst = 1'b1; rdRst = 1'b1;
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    // R6 flags held during reset
    chk("R6 inReady in reset", 64'(inReady), 64'd0);
    chk("R6 outReady in reset", 64'(outReady), 64'd0);
    chk("R6 almostEmpty in reset", 64'(almostEmpty), 64'd1);
    @(negedge wrClk) wrRst = 1'b0;
    @(negedge rdClk) rdRst = 1'b0;
    wrSeq = 0; rdSeq = 0; markSeq = 0;
    settle();
  endtask

  initial begin
    #700us;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    chk("R6 inReady after reset", 64'(inReady), 64'd1);
    chk("R6 almostFull after reset", 64'(almostFull), 64'd0);

    // table walk, default offsets of 8 (R6), coincident clocks
    foreach (STEPS[s]) begin
      writeN(STEPS[s].nW);
      settle();
      readN(STEPS[s].nR, STEPS[s].nR, "R1 table read");
      settle();
      chkFlags($sformatf("step %0d", s), STEPS[s].ir, STEPS[s].af,
               STEPS[s].orr, STEPS[s].ae);
    end

    // R7: parallel load af=510 (threshold 2), ae=2; load word is not stored
    doReset();
    @(negedge wrClk);
    cfgLoad = 1'b1;
    wrData  = (DATA_W'(2) << AE_LSB) | DATA_W'(510);
    @(negedge wrClk);
    cfgLoad = 1'b0;
    writeN(3);
    settle();
    chk("R7 almostFull at 3 with offset 510", 64'(almostFull), 64'd1);
    chk("R7 almostEmpty at 3 with offset 2", 64'(almostEmpty), 64'd0);
    readN(1, 1, "R7 first word after load");

    // R8: serial load ae=1, af=509 (threshold 3)
    doReset();
    for (int i = OFF_W - 1; i >= 0; i--) begin
      @(negedge wrClk); serEn = 1'b1; serIn = 1'(1 >> i);
    end
    for (int i = OFF_W - 1; i >= 0; i--) begin
      @(negedge wrClk); serEn = 1'b1; serIn = 1'(509 >> i);
    end
    @(negedge wrClk); serEn = 1'b0;
    writeN(2);
    settle();
    chk("R8 almostFull at 2", 64'(almostFull), 64'd0);
    chk("R8 almostEmpty at 2 with offset 1", 64'(almostEmpty), 64'd0);
    writeN(1);
    settle();
    chk("R8 almostFull at 3", 64'(almostFull), 64'd1);

    // R9: mark after first word, read three, rewind, replay
    doReset();
    writeN(6);
    settle();
    readN(1, 1, "R9 pre-mark read");
    pulseRd(0); markSeq = rdSeq;
    readN(3, 3, "R9 marked read");
    pulseRd(1); rdSeq = markSeq;
    readN(5, 5, "R9 replay read");
    settle();
    chk("R9 outReady after replay drains", 64'(outReady), 64'd0);

    // R11: rewind without a mark is ignored
    doReset();
    writeN(2);
    settle();
    readN(1, 1, "R11 read before go");
    pulseRd(1);
    readN(1, 1, "R11 read after unmarked go");

    // R10: held mark keeps full; drop frees space
    doReset();
    writeN(DEPTH);
    settle();
    pulseRd(0); markSeq = rdSeq;
    readN(10, 10, "R10 read while held");
    settle();
    chk("R10 inReady with mark held", 64'(inReady), 64'd0);
    writeN(1);
    pulseRd(2);
    settle();
    chk("R10 inReady after drop", 64'(inReady), 64'd1);
    chk("R10 almostFull after drop", 64'(almostFull), 64'd0);
    readN(DEPTH - 10, DEPTH - 10, "R10 remaining words");
    settle();
    chk("R10 outReady when drained", 64'(outReady), 64'd0);

    // R12: asynchronous read clock, concurrent traffic
    rdHalf = 3.1;
    doReset();
    fork
      writeN(40);
      readN(40, 4000, "R12 async read");
    join
    settle();
    chk("R12 words read", 64'(rdSeq), 64'd40);
    chkFlags("R12 end", 1'b1, 1'b0, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule